// File: doc/BRIEF.md
# Segmented address relocation and protection unit

This block turns a 16-bit virtual address into a 22-bit physical address. The address space is split into eight variable-length segments. Every segment owns a base register and a descriptor register. There is one register set for each privilege mode (kernel, supervisor, user). Inside each mode there is an instruction space and a data space, and each space holds eight segments, so the block stores 48 base/descriptor pairs in total. The three top virtual bits select the segment. The physical address is the segment base, counted in 64-byte blocks, plus the 13-bit offset inside the segment.

On every access the block checks three things: the segment length, the growth direction and a three-bit access code. It then returns one of three verdicts:
- pass: the access proceeds.
- abort: the access must not complete.
- trap: the access completes, and a trap follows afterwards.

The block also keeps two sticky flags in each descriptor. One records that the segment was written. The other records that a reference to it trapped. A plain configuration port loads both register kinds and reads them back combinationally.

Requests travel on a valid/ready handshake and so do the results. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. The result appears on `rsp_*` one cycle later. `req_ready` is high whenever the result register is empty or is being drained in the same cycle (`rsp_ready`). While `rsp_valid` is high and `rsp_ready` is low, the result is held unchanged and no new request is taken.

Top module: `segmmu_top`

## Requirements
- R1: After reset, every base and descriptor register reads zero and `rsp_valid` is low. Because access code 0 is then in force, any access made with relocation on is aborted.
- R2: With relocation on, `rsp_paddr` = (base × 64) + vaddr[12:0], truncated to 22 bits. The base is taken from the segment selected by vaddr[15:13].
- R3: `rsp_status` encodes pass as 0, abort as 1 and trap as 2, and the value 3 never appears. The access code sits in descriptor bits 2:0 and behaves as follows:
  - 0, 3 and 7: abort every access.
  - 1: abort on a write; trap on a read.
  - 2: abort on a write; pass on a read.
  - 4: trap every access.
  - 5: trap on a write; pass on a read.
  - 6: pass every access.
- R4: An upward segment (descriptor bit 3 clear) aborts when the block number vaddr[12:6] is greater than the length field in descriptor bits 14:8.
- R5: A downward segment (descriptor bit 3 set) aborts when the block number is less than the length field.
- R6: `split_en` has one bit per mode (bit 0 kernel, bit 1 supervisor, bit 2 user).
  - When a mode's bit is set, requests with `req_ispace` low use that mode's data-space registers.
  - When the bit is clear, every request in that mode uses the instruction-space registers.
  - `req_ispace` high always selects the instruction space.
- R7: `req_mode` selects the register set: 0 kernel, 1 supervisor, 2 user. Each set is independent of the others.
- R8: Two sticky flags are set when a request is taken with relocation on:
  - Descriptor bit 6 (written) is set by a write that is not aborted.
  - Descriptor bit 7 (trapped) is set by a trap verdict.
  - An aborted access changes neither flag.
- R9: A configuration write to a descriptor stores the length, direction and access code, and clears both flags. Readback follows this layout: bit 15 = 0, bits 14:8 = length, bit 7 = trapped, bit 6 = written, bits 5:4 = 0, bit 3 = direction, bits 2:0 = code. If a configuration write and a flag update hit the same descriptor in one cycle, the configuration write wins.
- R10: With `xlat_en` low, every access passes and no flag is touched.
  - When vaddr[15:13] is 7, the address is mapped to {6'h3F, vaddr}.
  - Otherwise the address is zero-extended.
- R11: `req_ready` = !rsp_valid || rsp_ready. While a result is stalled, `rsp_paddr` and `rsp_status` stay stable.
- R12: `req_mode` 3 has no register set. With relocation on it is aborted, and `rsp_paddr` is the zero-extended vaddr. Configuration accesses with `cfg_mode` 3 read zero and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlat_en | input | 1 | Relocation and protection enable |
| split_en | input | 3 | Per-mode enable for separate data space |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode of the register addressed |
| cfg_dspace | input | 1 | 1 = data-space register |
| cfg_seg | input | 3 | Segment number addressed |
| cfg_desc | input | 1 | 1 = descriptor, 0 = base |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Combinational readback of the addressed register |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_vaddr | input | 16 | Virtual address |
| req_mode | input | 2 | Privilege mode of the access |
| req_ispace | input | 1 | Instruction-class fetch (including immediate and absolute operands) |
| req_write | input | 1 | 1 = write access |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumed |
| rsp_paddr | output | 22 | Physical address |
| rsp_status | output | 2 | 0 pass, 1 abort, 2 trap |

## Verification
The bench targets the inclusive edges of both length checks:
- Upward segments: block 3 of a length-3 segment must pass, and block 4 must abort. An off-by-one comparison would flip one of these two verdicts.
- Downward segments: block 124 of a length-124 segment must pass, and block 123 must abort. A swapped direction would abort the wrong side.

A base of 0xFFFF with an offset of 0x40 checks that the sum wraps to address zero. It also drives data-space requests in a mode whose split bit is clear, so a design that ignored `split_en` would return the data-space base instead.

Two further checks cover the sticky flags:
- Reading the descriptors back confirms that aborted writes left the written flag clear. A design that updated flags before judging the access would show it set.
- A stalled result is watched over several cycles. A design that overwrote the result register under back-pressure would change the address.

// File: rtl/segmmu_pkg.sv
package segmmu_pkg;
  typedef enum logic [1:0] {
    VERD_PASS  = 2'd0,
    VERD_ABORT = 2'd1,
    VERD_TRAP  = 2'd2
  } verdict_e;

  // Descriptor state; the packed layout is internal, readback order is set by desc_pack.
  typedef struct packed {
    logic [6:0] len;
    logic       down;
    logic [2:0] acc;
    logic       trapped;
    logic       written;
  } desc_t;

  function automatic logic [15:0] desc_pack(desc_t d);
    return {1'b0, d.len, d.trapped, d.written, 2'b00, d.down, d.acc};
  endfunction

  function automatic desc_t desc_unpack(logic [15:0] w);
    desc_t d;
    d.len     = w[14:8];
    d.down    = w[3];
    d.acc     = w[2:0];
    d.trapped = 1'b0;
    d.written = 1'b0;
    return d;
  endfunction
endpackage

// File: rtl/segmmu_store.sv
module segmmu_store
  import segmmu_pkg::*;
#(
  parameter int NE     = 48,
  parameter int IW     = 6,
  parameter int BASE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_is_desc,
  input  logic [IW-1:0]     cfg_idx,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic [IW-1:0]     lk_idx,
  output logic [BASE_W-1:0] lk_base,
  output desc_t             lk_desc,
  input  logic              upd_en,
  input  logic [IW-1:0]     upd_idx,
  input  logic              upd_written,
  input  logic              upd_trapped
);
  logic [BASE_W-1:0] base_q [NE];
  desc_t             desc_q [NE];

  logic cfg_in_range, lk_in_range;
  assign cfg_in_range = {1'b0, cfg_idx} < (IW+1)'(NE);
  assign lk_in_range  = {1'b0, lk_idx} < (IW+1)'(NE);

  for (genvar e = 0; e < NE; e++) begin : g_entry
    logic cfg_hit, upd_hit;
    assign cfg_hit = cfg_wr && (cfg_idx == IW'(e));
    assign upd_hit = upd_en && (upd_idx == IW'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[e] <= '0;
        desc_q[e] <= '0;
      end else if (cfg_hit) begin
        if (cfg_is_desc) desc_q[e] <= desc_unpack(cfg_wdata);
        else             base_q[e] <= cfg_wdata[BASE_W-1:0];
      end else if (upd_hit) begin
        desc_q[e].written <= desc_q[e].written | upd_written;
        desc_q[e].trapped <= desc_q[e].trapped | upd_trapped;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_in_range)
      cfg_rdata = cfg_is_desc ? desc_pack(desc_q[cfg_idx]) : 16'(base_q[cfg_idx]);
  end

  assign lk_base = lk_in_range ? base_q[lk_idx] : '0;
  assign lk_desc = lk_in_range ? desc_q[lk_idx] : '0;

  // R8: a flag update not overridden by a configuration write leaves the flag set
  p_written_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && upd_written && !(cfg_wr && cfg_idx == upd_idx) |=> desc_q[$past(upd_idx)].written);
  p_trapped_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && upd_trapped && !(cfg_wr && cfg_idx == upd_idx) |=> desc_q[$past(upd_idx)].trapped);
endmodule

// File: rtl/segmmu_judge.sv
module segmmu_judge
  import segmmu_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             xlat_en,
  input  logic             mode_ok,
  input  logic             is_write,
  input  logic [LEN_W-1:0] blk,
  input  desc_t            desc,
  output verdict_e         verdict
);
  logic len_bad;
  assign len_bad = desc.down ? (blk < desc.len) : (blk > desc.len);

  always_comb begin
    verdict = VERD_PASS;
    if (!xlat_en) begin
      verdict = VERD_PASS;
    end else if (!mode_ok || len_bad) begin
      verdict = VERD_ABORT;
    end else begin
      unique case (desc.acc)
        3'd1:    verdict = is_write ? VERD_ABORT : VERD_TRAP;
        3'd2:    verdict = is_write ? VERD_ABORT : VERD_PASS;
        3'd4:    verdict = VERD_TRAP;
        3'd5:    verdict = is_write ? VERD_TRAP : VERD_PASS;
        3'd6:    verdict = VERD_PASS;
        default: verdict = VERD_ABORT;
      endcase
    end
  end
endmodule

// File: rtl/segmmu_top.sv
module segmmu_top
  import segmmu_pkg::*;
#(
  parameter int NM     = 3,
  parameter int MODE_W = 2,
  parameter int VA_W   = 16,
  parameter int PA_W   = 22,
  parameter int BASE_W = 16,
  parameter int SEG_W  = 3,
  parameter int BLK_W  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xlat_en,
  input  logic [NM-1:0]   split_en,
  input  logic            cfg_wr,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic            cfg_dspace,
  input  logic [SEG_W-1:0] cfg_seg,
  input  logic            cfg_desc,
  input  logic [15:0]     cfg_wdata,
  output logic [15:0]     cfg_rdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [MODE_W-1:0] req_mode,
  input  logic            req_ispace,
  input  logic            req_write,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [PA_W-1:0] rsp_paddr,
  output logic [1:0]      rsp_status
);
  localparam int NS    = 1 << SEG_W;
  localparam int NE    = NM * 2 * NS;
  localparam int IW    = MODE_W + 1 + SEG_W;
  localparam int OFF_W = VA_W - SEG_W;
  localparam int LEN_W = OFF_W - BLK_W;
  localparam int SPW   = 1 << MODE_W;

  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] off;
  logic [LEN_W-1:0] blk;
  logic [SPW-1:0]   split_pad;
  logic             mode_ok, use_d, accept;
  logic [IW-1:0]    lk_idx, cfg_idx;
  logic [BASE_W-1:0] lk_base;
  desc_t            lk_desc;
  verdict_e         verdict;
  logic [PA_W-1:0]  reloc_pa, flat_pa, pa_next;

  assign seg       = req_vaddr[VA_W-1 -: SEG_W];
  assign off       = req_vaddr[OFF_W-1:0];
  assign blk       = off[OFF_W-1:BLK_W];
  assign split_pad = SPW'(split_en);
  assign mode_ok   = {1'b0, req_mode} < (MODE_W+1)'(NM);
  assign use_d     = !req_ispace && split_pad[req_mode];
  assign lk_idx    = {req_mode, use_d, seg};
  assign cfg_idx   = {cfg_mode, cfg_dspace, cfg_seg};

  segmmu_store #(.NE(NE), .IW(IW), .BASE_W(BASE_W)) u_store (
    .clk, .rst_n,
    .cfg_wr, .cfg_is_desc(cfg_desc), .cfg_idx, .cfg_wdata, .cfg_rdata,
    .lk_idx, .lk_base, .lk_desc,
    .upd_en(accept && xlat_en && mode_ok), .upd_idx(lk_idx),
    .upd_written(req_write && verdict != VERD_ABORT),
    .upd_trapped(verdict == VERD_TRAP)
  );

  segmmu_judge #(.LEN_W(LEN_W)) u_judge (
    .xlat_en, .mode_ok, .is_write(req_write), .blk, .desc(lk_desc), .verdict
  );

  assign reloc_pa = PA_W'({lk_base, {BLK_W{1'b0}}}) + PA_W'(off);
  assign flat_pa  = (&seg) ? {{(PA_W-VA_W){1'b1}}, req_vaddr} : PA_W'(req_vaddr);
  assign pa_next  = (xlat_en && mode_ok) ? reloc_pa : flat_pa;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  verdict_e status_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      status_q  <= VERD_PASS;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr <= (xlat_en && !mode_ok) ? PA_W'(req_vaddr) : pa_next;
        status_q  <= verdict;
      end
    end
  end
  assign rsp_status = status_q;

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_status));
  p_stall_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
  p_status_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status != 2'd3);
  p_nonresident_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && xlat_en && mode_ok && lk_desc.acc == 3'd0 |=> rsp_status == VERD_ABORT);
  p_len_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && xlat_en && mode_ok && !lk_desc.down && blk > lk_desc.len |=> rsp_status == VERD_ABORT);
  p_len_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && xlat_en && mode_ok && lk_desc.down && blk < lk_desc.len |=> rsp_status == VERD_ABORT);
  p_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !xlat_en |=> rsp_status == VERD_PASS && rsp_paddr[VA_W-1:0] == $past(req_vaddr));
  p_bad_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
    accept && xlat_en && !mode_ok |=> rsp_status == VERD_ABORT);
endmodule

// File: tb/segmmu_top_tb.sv
`timescale 1ns/1ps
module segmmu_top_tb;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic xlat_en = 0;
  logic [2:0] split_en = 3'b011;
  logic cfg_wr = 0, cfg_dspace = 0, cfg_desc = 0;
  logic [1:0] cfg_mode = 0;
  logic [2:0] cfg_seg = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic req_valid = 0, req_ready, req_ispace = 0, req_write = 0;
  logic [15:0] req_vaddr = 0;
  logic [1:0] req_mode = 0;
  logic rsp_valid, rsp_ready = 1;
  logic [21:0] rsp_paddr;
  logic [1:0] rsp_status;

  segmmu_top u_dut (.*);

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_put(logic [1:0] m, logic d, logic [2:0] s, logic isdesc, logic [15:0] w);
    @(negedge clk);
    cfg_wr = 1; cfg_mode = m; cfg_dspace = d; cfg_seg = s; cfg_desc = isdesc; cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic cfg_chk(string req, logic [1:0] m, logic d, logic [2:0] s, logic isdesc, logic [15:0] exp);
    @(negedge clk);
    cfg_mode = m; cfg_dspace = d; cfg_seg = s; cfg_desc = isdesc;
    #1 check(req, 32'(cfg_rdata), 32'(exp));
  endtask

  task automatic access(logic [1:0] m, logic isp, logic wr, logic [15:0] va);
    @(negedge clk);
    req_valid = 1; req_mode = m; req_ispace = isp; req_write = wr; req_vaddr = va;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  // {mode, ispace, write, vaddr, status, paddr}
  localparam int NV = 21;
  localparam logic [43:0] VEC [NV] = '{
    {2'd0,1'b1,1'b0,16'h0123,2'd0,22'h004123},  // R2 R7 kernel I seg0
    {2'd0,1'b0,1'b0,16'h0040,2'd0,22'h000000},  // R2 R6 kernel D wrap to 0
    {2'd0,1'b1,1'b1,16'h00C0,2'd0,22'h0040C0},  // R3 code 6 write
    {2'd0,1'b1,1'b0,16'h20FF,2'd0,22'h0080FF},  // R4 block == length passes
    {2'd0,1'b1,1'b0,16'h2100,2'd1,22'h008100},  // R4 block > length aborts
    {2'd0,1'b1,1'b1,16'h2000,2'd1,22'h008000},  // R3 code 2 write aborts
    {2'd0,1'b1,1'b0,16'h5F00,2'd0,22'h00DF00},  // R5 down block == length passes
    {2'd0,1'b1,1'b0,16'h5EFF,2'd1,22'h00DEFF},  // R5 down block < length aborts
    {2'd0,1'b1,1'b0,16'h6000,2'd2,22'h010000},  // R3 code 1 read traps
    {2'd0,1'b1,1'b1,16'h6000,2'd1,22'h010000},  // R3 code 1 write aborts
    {2'd0,1'b1,1'b0,16'h8000,2'd2,22'h014000},  // R3 code 4 read traps
    {2'd0,1'b1,1'b1,16'hA000,2'd2,22'h018000},  // R3 code 5 write traps
    {2'd0,1'b1,1'b0,16'hA000,2'd0,22'h018000},  // R3 code 5 read passes
    {2'd0,1'b1,1'b0,16'hC000,2'd1,22'h000000},  // R3 code 3 aborts
    {2'd0,1'b1,1'b0,16'hE000,2'd1,22'h000000},  // R3 code 7 aborts
    {2'd2,1'b0,1'b0,16'h0010,2'd0,22'h020010},  // R6 user split off -> I set
    {2'd2,1'b1,1'b0,16'h0010,2'd0,22'h020010},  // R7 user I
    {2'd1,1'b0,1'b1,16'h0000,2'd1,22'h02C000},  // R6 super D read-only write
    {2'd1,1'b1,1'b1,16'h0000,2'd0,22'h028000},  // R7 super I write
    {2'd1,1'b0,1'b0,16'h0004,2'd0,22'h02C004},  // R6 super D read
    {2'd3,1'b1,1'b0,16'h0000,2'd1,22'h000000}   // R12 no register set
  };

  initial begin
    #(4ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    cfg_chk("R1 desc reset", 0, 0, 0, 1, 16'h0000);
    cfg_chk("R1 base reset", 2, 1, 7, 0, 16'h0000);
    xlat_en = 1;
    access(0, 1, 0, 16'h0000);
    check("R1 rsp_valid", 32'(rsp_valid), 1);
    check("R1 abort after reset", 32'(rsp_status), 1);

    cfg_put(0,0,0,0,16'h0100); cfg_put(0,0,0,1,16'h7F06);
    cfg_put(0,0,1,0,16'h0200); cfg_put(0,0,1,1,16'h0302);
    cfg_put(0,0,2,0,16'h0300); cfg_put(0,0,2,1,16'h7C0E);
    cfg_put(0,0,3,0,16'h0400); cfg_put(0,0,3,1,16'h7F01);
    cfg_put(0,0,4,0,16'h0500); cfg_put(0,0,4,1,16'h7F04);
    cfg_put(0,0,5,0,16'h0600); cfg_put(0,0,5,1,16'h7F05);
    cfg_put(0,0,6,1,16'h7F03); cfg_put(0,0,7,1,16'h7F07);
    cfg_put(0,1,0,0,16'hFFFF); cfg_put(0,1,0,1,16'h7F06);
    cfg_put(2,0,0,0,16'h0800); cfg_put(2,0,0,1,16'h7F06);
    cfg_put(2,1,0,0,16'h0900); cfg_put(2,1,0,1,16'h7F06);
    cfg_put(1,0,0,0,16'h0A00); cfg_put(1,0,0,1,16'h7F06);
    cfg_put(1,1,0,0,16'h0B00); cfg_put(1,1,0,1,16'h7F02);
    cfg_put(3,0,0,1,16'h7F06);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][43:42], VEC[i][41], VEC[i][40], VEC[i][39:24]);
      check($sformatf("R2/R3 vec %0d status", i), 32'(rsp_status), 32'(VEC[i][23:22]));
      check($sformatf("R2 vec %0d paddr", i), 32'(rsp_paddr), 32'(VEC[i][21:0]));
    end

    // R8 flags; R9 layout
    cfg_chk("R8 written after write", 0, 0, 0, 1, 16'h7F46);
    cfg_chk("R8 aborted leaves flags", 0, 0, 1, 1, 16'h0302);
    cfg_chk("R8 trapped read", 0, 0, 4, 1, 16'h7F84);
    cfg_chk("R8 trap on write sets both", 0, 0, 5, 1, 16'h7FC5);
    cfg_chk("R8 code1 trap then abort", 0, 0, 3, 1, 16'h7F81);
    cfg_chk("R8 super D abort write", 1, 1, 0, 1, 16'h7F02);
    cfg_chk("R9 base readback", 0, 1, 0, 0, 16'hFFFF);
    cfg_chk("R12 cfg mode 3 reads zero", 3, 0, 0, 1, 16'h0000);
    cfg_put(0,0,0,1,16'h7F06);
    cfg_chk("R9 rewrite clears flags", 0, 0, 0, 1, 16'h7F06);

    // R10 relocation off
    xlat_en = 0;
    access(0, 1, 1, 16'h1234);
    check("R10 status", 32'(rsp_status), 0);
    check("R10 paddr low", 32'(rsp_paddr), 32'h001234);
    access(0, 1, 1, 16'hE010);
    check("R10 io page", 32'(rsp_paddr), 32'h3FE010);
    access(0, 1, 1, 16'h0000);
    cfg_chk("R10 no flag update", 0, 0, 0, 1, 16'h7F06);
    access(0, 1, 1, 16'h2000);
    check("R10 ro segment passes", 32'(rsp_status), 0);
    xlat_en = 1;

    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 0;
    access(2, 1, 0, 16'h0020);
    check("R11 first valid", 32'(rsp_valid), 1);
    check("R11 ready low", 32'(req_ready), 0);
    req_valid = 1; req_mode = 0; req_ispace = 1; req_write = 0; req_vaddr = 16'h0100;
    @(negedge clk); @(negedge clk);
    check("R11 held paddr", 32'(rsp_paddr), 32'h020020);
    check("R11 still blocked", 32'(req_ready), 0);
    rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check("R11 second valid", 32'(rsp_valid), 1);
    check("R11 second paddr", 32'(rsp_paddr), 32'h004100);
    @(negedge clk);
    check("R11 drained", 32'(rsp_valid), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule